// File: doc/BRIEF.md
# Cycle-Stealing DMA Channel Engine

This block is one self-starting, dual-address DMA channel. Software supplies a source pointer, a destination pointer, a 24-bit unit count, a unit size and a bus-sharing mode, then pulses `start`. The channel then requests the bus on its own. For every unit it reads from the source and writes to the destination, and it advances both pointers by the unit size after each unit. A unit is 1, 2 or 4 bytes, or a 16-byte block. The block is moved as four longword reads into an internal buffer followed by four longword writes, and the bus is not released inside it.

Three bus-sharing modes exist. Burst mode holds the bus request from the first grant until the final unit. Normal cycle-stealing drops the request for one clock after every unit. Intermittent cycle-stealing leaves the bus idle for 16 or 64 clocks between units. A count of zero means 2^24 units. Two sticky interrupt flags are provided. The half flag is raised when the remaining count first reaches half of the starting count, and the end flag is raised when the count reaches zero. Each flag stays set until its clear input is pulsed.

The bus port is simple. The channel raises `bus_req`, and it issues an access (`bus_valid`) only while `bus_gnt` is high. An access completes in a cycle where `bus_ready` is high, and read data is sampled in that cycle. Data is right-justified on the data buses. Pointers are assumed aligned to the access size.

Top module: `dma_chan`

## Requirements
- R1: Unit size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes. After each unit, both pointers advance by that many bytes, so the destination receives an exact copy of count × size bytes and the byte after that range is untouched. `bus_size` uses 0 = byte, 1 = 2 bytes, 2 = 4 bytes.
- R2: A 16-byte unit is issued as four 4-byte reads at consecutive addresses, then four 4-byte writes, with `bus_req` held high across all eight accesses.
- R3: A programmed count of 0 loads 2^24 into `xfer_left`.
- R4: `xfer_left` drops by exactly one per completed unit. When it reaches zero, `busy` falls, `irq_end` is set, and no further bus request is made. After reset, `busy`, `bus_req`, `irq_half`, `irq_end` and `xfer_left` are all 0.
- R5: In normal cycle-stealing mode (`cfg_burst`=0, `cfg_intermit`=0), `bus_req` is low for exactly one clock between consecutive units.
- R6: In burst mode (`cfg_burst`=1), `bus_req` stays high from the first request until the last unit completes, so it falls exactly once per job.
- R7: In intermittent mode (`cfg_burst`=0, `cfg_intermit`=1), `bus_req` is low for exactly 16 clocks between units when `cfg_gap_long`=0, and 64 clocks when it is 1.
- R8: `irq_half` is 0 while `xfer_left` is above floor(initial/2). It becomes 1 in the same cycle that `xfer_left` reaches that value.
- R9: `irq_half` and `irq_end` stay set until a one-cycle pulse on `clr_half` or `clr_end` clears the corresponding flag. The other flag is unaffected.
- R10: A `start` pulse while idle raises `bus_req` in the next cycle with no other trigger. A `start` pulse while busy is ignored.
- R11: `bus_valid` is only asserted while `bus_gnt` is high. While the grant is withheld, no access occurs and the count does not move. Wait states on `bus_ready` stretch accesses without loss of data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that starts a job when idle |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_count | input | 24 | Number of units (0 = 2^24) |
| cfg_unit | input | 2 | Unit size code |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle-stealing |
| cfg_intermit | input | 1 | Idle gap between units in cycle-stealing |
| cfg_gap_long | input | 1 | Gap length: 0 = 16, 1 = 64 clocks |
| clr_half | input | 1 | Clears the half flag |
| clr_end | input | 1 | Clears the end flag |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Access valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Job in progress |
| xfer_left | output | 25 | Remaining unit count |
| irq_half | output | 1 | Sticky half-way flag |
| irq_end | output | 1 | Sticky completion flag |

## Verification
Copies are run for every unit size, and each size is paired with a different bus-sharing mode. This separates pointer stepping, which shows in the copied data and in the untouched guard byte, from request sequencing, which shows in the length of the low runs on `bus_req` and the number of accesses per hold. Odd and even counts distinguish the floor in the half-way point. A held-back grant and a toggling ready show that accesses wait for the bus rather than losing data. A zero count and a mid-job `start` pulse are observed through `xfer_left`, to tell "2^24" apart from "nothing" and to show that a reload is ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        UNIT_B1  = 2'd0,
        UNIT_B2  = 2'd1,
        UNIT_B4  = 2'd2,
        UNIT_B16 = 2'd3
    } unit_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL,
        ST_GAP
    } chan_state_e;

    // bytes moved by one unit
    function automatic logic [4:0] unit_bytes(unit_e u);
        case (u)
            UNIT_B1:  return 5'd1;
            UNIT_B2:  return 5'd2;
            UNIT_B4:  return 5'd4;
            default:  return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
    parameter int AW     = 32,
    parameter int STEP_W = 5,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     load_addr,
    input  logic              step,
    input  logic [STEP_W-1:0] step_bytes,
    input  logic [BEAT_W-1:0] beat,
    output logic [AW-1:0]     beat_addr
);
    typedef struct packed {
        logic [AW-1:0] base;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d.base = load_addr;
        end else if (step) begin
            ptr_d.base = ptr_q.base + AW'(step_bytes);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // beats inside a unit are longwords
    assign beat_addr = ptr_q.base + (AW'(beat) << 2);

endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
    parameter int CW = 24,
    localparam int LW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_count,
    input  logic          dec,
    input  logic          clr_half,
    input  logic          clr_end,
    output logic [LW-1:0] left,
    output logic          last,
    output logic          half_flag,
    output logic          end_flag
);
    typedef struct packed {
        logic [LW-1:0] left;
        logic [LW-1:0] half_pt;
        logic          half;
        logic          fin;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [LW-1:0] eff;
    logic [LW-1:0] left_m1;
    logic          set_half;
    logic          set_end;

    always_comb begin
        eff      = (load_count == '0) ? (LW'(1) << CW) : LW'(load_count);
        left_m1  = c_q.left - LW'(1);
        set_half = dec && (c_q.left != '0) && (left_m1 == c_q.half_pt);
        set_end  = dec && (c_q.left == LW'(1));

        c_d = c_q;
        if (load) begin
            c_d.left    = eff;
            c_d.half_pt = eff >> 1;
        end else if (dec && (c_q.left != '0)) begin
            c_d.left = left_m1;
        end

        // a set in the same cycle wins over a clear
        if (set_half)      c_d.half = 1'b1;
        else if (clr_half) c_d.half = 1'b0;
        if (set_end)       c_d.fin  = 1'b1;
        else if (clr_end)  c_d.fin  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign left      = c_q.left;
    assign last      = (c_q.left == LW'(1));
    assign half_flag = c_q.half;
    assign end_flag  = c_q.fin;

endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64,
    localparam int GW = $clog2(GAP_LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    output logic expire
);
    typedef struct packed {
        logic [GW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = sel_long ? GW'(GAP_LONG) : GW'(GAP_SHORT);
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - GW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expire = (t_q.cnt == GW'(1));

endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 24,
    parameter int BEATS     = 4,
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_unit,
    input  logic          cfg_burst,
    input  logic          cfg_intermit,
    input  logic          cfg_gap_long,
    input  logic          clr_half,
    input  logic          clr_end,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          busy,
    output logic [CW:0]   xfer_left,
    output logic          irq_half,
    output logic          irq_end
);
    import dma_pkg::*;

    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int NPTR   = 2;   // 0: source, 1: destination

    typedef struct packed {
        chan_state_e              state;
        logic [BEAT_W-1:0]        beat;
        unit_e                    unit;
        logic                     burst;
        logic                     intermit;
        logic                     gap_long;
        logic [BEATS-1:0][DW-1:0] hold;
    } chan_t;

    chan_t s_d, s_q;

    logic                        job_load;
    logic                        unit_done;
    logic                        cnt_last;
    logic                        gap_load;
    logic                        gap_expire;
    logic                        xfer_ok;
    logic [BEAT_W-1:0]           last_beat;
    logic [NPTR-1:0][AW-1:0]     ptr_init;
    logic [NPTR-1:0][AW-1:0]     ptr_addr;
    logic [4:0]                  step_bytes;

    assign job_load   = start && (s_q.state == ST_IDLE);
    assign xfer_ok    = bus_gnt && bus_ready;
    assign last_beat  = (s_q.unit == UNIT_B16) ? BEAT_W'(BEATS - 1) : '0;
    assign step_bytes = unit_bytes(s_q.unit);
    assign ptr_init[0] = cfg_src;
    assign ptr_init[1] = cfg_dst;

    // one pointer per side, same structure
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma_addr_ctr #(
            .AW     (AW),
            .STEP_W (5),
            .BEAT_W (BEAT_W)
        ) u_ptr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (job_load),
            .load_addr  (ptr_init[g]),
            .step       (unit_done),
            .step_bytes (step_bytes),
            .beat       (s_q.beat),
            .beat_addr  (ptr_addr[g])
        );
    end

    dma_xfer_cnt #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (job_load),
        .load_count (cfg_count),
        .dec        (unit_done),
        .clr_half   (clr_half),
        .clr_end    (clr_end),
        .left       (xfer_left),
        .last       (cnt_last),
        .half_flag  (irq_half),
        .end_flag   (irq_end)
    );

    dma_gap_timer #(
        .GAP_SHORT (GAP_SHORT),
        .GAP_LONG  (GAP_LONG)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .sel_long (s_q.gap_long),
        .expire   (gap_expire)
    );

    always_comb begin
        s_d       = s_q;
        unit_done = 1'b0;
        gap_load  = 1'b0;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = ptr_addr[0];
        bus_wdata = s_q.hold[s_q.beat];
        bus_size  = (s_q.unit == UNIT_B16) ? 2'(UNIT_B4) : 2'(s_q.unit);

        case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state    = ST_REQ;
                    s_d.beat     = '0;
                    s_d.unit     = unit_e'(cfg_unit);
                    s_d.burst    = cfg_burst;
                    s_d.intermit = cfg_intermit;
                    s_d.gap_long = cfg_gap_long;
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    s_d.state = ST_RD;
                    s_d.beat  = '0;
                end
            end
            ST_RD: begin
                bus_req   = 1'b1;
                bus_valid = bus_gnt;
                bus_addr  = ptr_addr[0];
                if (xfer_ok) begin
                    s_d.hold[s_q.beat] = bus_rdata;
                    if (s_q.beat == last_beat) begin
                        s_d.state = ST_WR;
                        s_d.beat  = '0;
                    end else begin
                        s_d.beat = s_q.beat + BEAT_W'(1);
                    end
                end
            end
            ST_WR: begin
                bus_req   = 1'b1;
                bus_valid = bus_gnt;
                bus_we    = 1'b1;
                bus_addr  = ptr_addr[1];
                if (xfer_ok) begin
                    if (s_q.beat == last_beat) begin
                        unit_done = 1'b1;
                        s_d.beat  = '0;
                        if (cnt_last) begin
                            s_d.state = ST_IDLE;
                        end else if (s_q.burst) begin
                            s_d.state = ST_RD;
                        end else if (s_q.intermit) begin
                            s_d.state = ST_GAP;
                            gap_load  = 1'b1;
                        end else begin
                            s_d.state = ST_REL;
                        end
                    end else begin
                        s_d.beat = s_q.beat + BEAT_W'(1);
                    end
                end
            end
            ST_REL: begin
                s_d.state = ST_REQ;
            end
            ST_GAP: begin
                if (gap_expire) s_d.state = ST_REQ;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.state != ST_IDLE);

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter int CW = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        clr_half,
    input logic        clr_end,
    input logic        bus_req,
    input logic        bus_gnt,
    input logic        bus_valid,
    input logic        busy,
    input logic [CW:0] xfer_left,
    input logic        irq_half,
    input logic        irq_end
);
    p_access_granted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_gnt && bus_req));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_valid && !bus_req));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && (xfer_left != $past(xfer_left)))
            |-> (xfer_left == $past(xfer_left) - (CW+1)'(1)));

    p_end_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_end && !clr_end) |=> irq_end);

    p_half_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_half && !clr_half) |=> irq_half);

endmodule

bind dma_chan dma_chan_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .clr_half  (clr_half),
    .clr_end   (clr_end),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_valid (bus_valid),
    .busy      (busy),
    .xfer_left (xfer_left),
    .irq_half  (irq_half),
    .irq_end   (irq_end)
);

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [23:0] cfg_count = '0;
    logic [1:0]  cfg_unit = '0;
    logic        cfg_burst = 1'b0, cfg_intermit = 1'b0, cfg_gap_long = 1'b0;
    logic        clr_half = 1'b0, clr_end = 1'b0;
    logic        bus_req, bus_gnt, bus_valid, bus_we, bus_ready;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        busy, irq_half, irq_end;
    logic [24:0] xfer_left;

    logic        gnt_en = 1'b1;
    logic        stall_en = 1'b0;
    logic        tgl = 1'b0;
    logic [7:0]  mem [0:1023];

    int checks = 0, errors = 0, cycles = 0;
    // monitor state
    int acc_cnt = 0, falls = 0, low_run = 0, low_min = 0, low_max = 0;
    int hold_acc = 0, hold_min = 0, hold_max = 0, half_bad = 0;
    int half_exp = 0;
    bit mon_half = 1'b0, prev_req = 1'b0;

    always #2.5 clk = ~clk;

    dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_unit(cfg_unit), .cfg_burst(cfg_burst), .cfg_intermit(cfg_intermit),
        .cfg_gap_long(cfg_gap_long), .clr_half(clr_half), .clr_end(clr_end),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy),
        .xfer_left(xfer_left), .irq_half(irq_half), .irq_end(irq_end)
    );

    assign bus_gnt   = bus_req && gnt_en;
    assign bus_ready = stall_en ? tgl : 1'b1;

    logic [9:0] ma;
    assign ma = bus_addr[9:0];
    always_comb begin
        bus_rdata = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};
        if (bus_size == 2'd0)      bus_rdata = {24'd0, mem[ma]};
        else if (bus_size == 2'd1) bus_rdata = {16'd0, mem[ma + 10'd1], mem[ma]};
    end

    always @(posedge clk) begin
        tgl <= ~tgl;
        if (bus_valid && bus_we && bus_gnt && bus_ready) begin
            mem[ma] <= bus_wdata[7:0];
            if (bus_size >= 2'd1) mem[ma + 10'd1] <= bus_wdata[15:8];
            if (bus_size == 2'd2) begin
                mem[ma + 10'd2] <= bus_wdata[23:16];
                mem[ma + 10'd3] <= bus_wdata[31:24];
            end
        end
    end

    // activity monitor, sampled at the edge on pre-edge values
    always @(posedge clk) begin
        if (bus_valid && bus_gnt && bus_ready) begin
            acc_cnt  <= acc_cnt + 1;
            hold_acc <= hold_acc + 1;
        end
        if (prev_req && !bus_req) begin
            falls <= falls + 1;
            if (hold_min == 0 || hold_acc < hold_min) hold_min <= hold_acc;
            if (hold_acc > hold_max) hold_max <= hold_acc;
            hold_acc <= 0;
        end
        prev_req <= bus_req;
        if (busy && !bus_req) begin
            low_run <= low_run + 1;
        end else begin
            if (busy && bus_req && low_run > 0) begin
                if (low_min == 0 || low_run < low_min) low_min <= low_run;
                if (low_run > low_max) low_max <= low_run;
            end
            low_run <= 0;
        end
        if (mon_half && busy) begin
            if (irq_half != (int'(xfer_left) <= half_exp)) half_bad <= half_bad + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_flags();
        clr_half = 1'b1;
        clr_end  = 1'b1;
        @(negedge clk);
        clr_half = 1'b0;
        clr_end  = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    // one directed copy job with all its checks
    task automatic run_copy(input string req, input int unit, input int count,
                            input bit burst, input bit inter, input bit glong,
                            input int src, input int dst, input bit stall,
                            input int gnt_delay);
        int ub, beats, nbytes, bad, guard, gap;
        ub     = (unit == 3) ? 16 : (1 << unit);
        beats  = (unit == 3) ? 4 : 1;
        nbytes = count * ub;
        clear_flags();
        for (int i = 0; i < nbytes; i++) mem[src + i] = 8'((src + i * 7 + unit * 13 + 1) & 255);
        for (int i = 0; i < nbytes + 4; i++) mem[dst + i] = 8'h00;
        stall_en = stall;
        gnt_en   = (gnt_delay == 0);
        acc_cnt = 0; falls = 0; low_min = 0; low_max = 0;
        hold_acc = 0; hold_min = 0; hold_max = 0; half_bad = 0;
        half_exp = count / 2;
        cfg_src = 32'(src); cfg_dst = 32'(dst); cfg_count = 24'(count);
        cfg_unit = 2'(unit); cfg_burst = burst; cfg_intermit = inter; cfg_gap_long = glong;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mon_half = 1'b1;
        chk(bus_req == 1'b1, "R10", "request one cycle after start", bus_req, 1);
        if (gnt_delay > 0) begin
            repeat (gnt_delay) @(negedge clk);
            chk(acc_cnt == 0, "R11", "accesses while grant withheld", acc_cnt, 0);
            chk(int'(xfer_left) == count, "R11", "count while grant withheld", xfer_left, count);
            gnt_en = 1'b1;
        end
        wait_idle(20000);
        @(negedge clk);
        mon_half = 1'b0;
        bad = 0;
        for (int i = 0; i < nbytes; i++) if (mem[dst + i] != mem[src + i]) bad++;
        guard = 0;
        for (int i = nbytes; i < nbytes + 4; i++) if (mem[dst + i] != 8'h00) guard++;
        chk(bad == 0, req, "R1 copied bytes mismatching", bad, 0);
        chk(guard == 0, req, "R1 bytes written past range", guard, 0);
        chk(acc_cnt == 2 * count * beats, req, "R2 access count", acc_cnt, 2 * count * beats);
        chk(irq_end == 1'b1 && busy == 1'b0, req, "R4 end flag set and idle", irq_end, 1);
        chk(xfer_left == 25'd0, req, "R4 remaining count", xfer_left, 0);
        chk(half_bad == 0, req, "R8 half flag vs remaining count", half_bad, 0);
        if (burst) begin
            chk(falls == 1, req, "R6 request falls per job", falls, 1);
        end else begin
            chk(falls == count, req, "R5 request falls per job", falls, count);
            if (count > 1) begin
                gap = inter ? (glong ? 64 : 16) : 1;
                chk(low_min == gap && low_max == gap, req, "R5/R7 idle clocks between units",
                    low_max, gap);
            end
            if (unit == 3)
                chk(hold_min == 8 && hold_max == 8, req, "R2 accesses per bus hold", hold_min, 8);
        end
        stall_en = 1'b0;
        gnt_en   = 1'b1;
    endtask

    task automatic t_reset_state();
        chk(busy == 1'b0 && bus_req == 1'b0, "R4", "reset busy/request", busy, 0);
        chk(irq_half == 1'b0 && irq_end == 1'b0, "R4", "reset flags", irq_end, 0);
        chk(xfer_left == 25'd0, "R4", "reset count", xfer_left, 0);
    endtask

    task automatic t_count_zero();
        clear_flags();
        cfg_src = 32'd0; cfg_dst = 32'd512; cfg_count = 24'd0; cfg_unit = 2'd0;
        cfg_burst = 1'b0; cfg_intermit = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(xfer_left == 25'h1000000, "R3", "count zero loads 2^24", xfer_left, 25'h1000000);
        for (int i = 0; i < 200; i++) begin
            if (xfer_left == 25'h1000000 - 25'd5) break;
            @(negedge clk);
        end
        chk(xfer_left == 25'h1000000 - 25'd5, "R3", "count after five units", xfer_left,
            25'h1000000 - 25'd5);
        chk(busy == 1'b1 && irq_half == 1'b0 && irq_end == 1'b0, "R3",
            "still running, no flags", {busy, irq_half, irq_end}, 3'b100);
        do_reset();
    endtask

    task automatic t_start_ignored();
        int bad;
        clear_flags();
        for (int i = 0; i < 16; i++) begin mem[100 + i] = 8'(i + 40); mem[700 + i] = 8'h00; end
        cfg_src = 32'd100; cfg_dst = 32'd700; cfg_count = 24'd6; cfg_unit = 2'd0;
        cfg_burst = 1'b0; cfg_intermit = 1'b0;
        acc_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (xfer_left == 25'd4) break;
            @(negedge clk);
        end
        cfg_count = 24'd100; cfg_src = 32'd300;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(xfer_left) <= 4, "R10", "start while busy does not reload", xfer_left, 4);
        wait_idle(2000);
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 6; i++) if (mem[700 + i] != 8'(i + 40)) bad++;
        chk(bad == 0 && mem[706] == 8'h00, "R10", "first job completed unchanged", bad, 0);
        chk(acc_cnt == 12, "R10", "access count of first job only", acc_cnt, 12);
    endtask

    task automatic t_sticky_clear();
        repeat (10) @(negedge clk);
        chk(irq_end == 1'b1 && irq_half == 1'b1, "R9", "flags held while idle",
            {irq_half, irq_end}, 3);
        clr_end = 1'b1;
        @(negedge clk);
        clr_end = 1'b0;
        chk(irq_end == 1'b0 && irq_half == 1'b1, "R9", "end cleared, half kept",
            {irq_half, irq_end}, 2);
        clr_half = 1'b1;
        @(negedge clk);
        clr_half = 1'b0;
        chk(irq_half == 1'b0 && irq_end == 1'b0, "R9", "half cleared",
            {irq_half, irq_end}, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        do_reset();
        t_reset_state();
        run_copy("R1/R5 byte normal", 0, 5, 1'b0, 1'b0, 1'b0, 0, 512, 1'b0, 0);
        run_copy("R1/R6 word burst", 1, 4, 1'b1, 1'b0, 1'b0, 64, 600, 1'b0, 0);
        run_copy("R1/R7 long gap16", 2, 3, 1'b0, 1'b1, 1'b0, 128, 640, 1'b0, 0);
        run_copy("R2/R5 block normal", 3, 3, 1'b0, 1'b0, 1'b0, 192, 704, 1'b0, 0);
        run_copy("R2/R11 block burst stall", 3, 2, 1'b1, 1'b0, 1'b0, 256, 768, 1'b1, 0);
        run_copy("R7 byte gap64", 0, 3, 1'b0, 1'b1, 1'b1, 320, 832, 1'b0, 0);
        run_copy("R11 grant held back", 2, 2, 1'b0, 1'b0, 1'b0, 340, 860, 1'b0, 10);
        run_copy("R8 single unit", 1, 1, 1'b0, 1'b0, 1'b0, 360, 880, 1'b0, 0);
        t_sticky_clear();
        t_start_ignored();
        t_count_zero();
        t_reset_state();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule